// File: doc/BRIEF.md
# Indexed Interrupt Routing Register File

This block holds the programmable state of an I/O interrupt controller. Software reaches it through an index/data pair. It first writes an index with one strobe. It then reads or writes the selected 32-bit word through the data window with separate strobes. The word space holds an identification word, a read-only version word, a read-only arbitration word, and a 64-bit routing entry for each interrupt input line. Each routing entry is stored as two 32-bit halves that are written independently.

Each routing entry drives per-line fields straight into the delivery engine: vector, delivery mode, destination mode, destination and trigger mode. It also drives a mask bit, which is set at reset. The delivery engine sends back a remote-IRR bit and a delivery-status bit for each line. These two bits appear live in the low word on every read and cannot be written. Message delivery and input sensing are handled elsewhere.

Top module: `intc_ind_regs`

## Requirements
- R1: Index 0x00 is the identification word. Only bits 27:24 accept writes, and all other bits always read 0. After reset it reads 0.
- R2: Index 0x01 always reads the constant 0x00170011 with the defaults: bits 23:16 hold the highest entry number (NUM_LINES-1) and bits 7:0 hold VER_CODE. Writes leave this readback unchanged.
- R3: Index 0x02 reads bits 27:24 copied from the most recent write to index 0x00, with all other bits 0. Writes to index 0x02 are ignored. After reset it reads 0.
- R4: A pulse on `idx_we` loads `wdata[7:0]` as the index. Later data-window reads and writes act on the word at that index.
- R5: Line n's low word is at index 0x10+2n and its high word is at 0x11+2n. The low-word layout is: vector [7:0], delivery mode [10:8], destination mode [11] (0 physical, 1 logical), delivery status [12], polarity [13], remote IRR [14], trigger mode [15], mask [16]. All other low-word bits read 0.
- R6: A high-word write changes only the destination in bits 31:24. Other high-word bits read 0, and the line's low-word fields stay unchanged.
- R7: A low-word write leaves the line's destination unchanged.
- R8: Bits 12 and 14 of a low-word read show the `dlv_stat_i` and `remote_irr_i` inputs of that line as sampled on the read edge. Writes to those bit positions have no effect.
- R9: After reset every line's mask is 1 and all its other stored fields are 0.
- R10: The per-line output ports always show the stored vector, delivery mode, destination mode, destination, trigger mode and mask of each line. Line n occupies slice n of each port.
- R11: Indices that hold no word read 0, and writes to them have no effect on any readback or output.
- R12: `rdata` loads the selected word on a clock edge where `rd_en` is 1. It holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Load index from wdata[7:0] |
| dat_we | input | 1 | Write wdata to the indexed word |
| rd_en | input | 1 | Capture the indexed word into rdata |
| wdata | input | 32 | Write data for index and data window |
| rdata | output | 32 | Registered read data |
| remote_irr_i | input | NUM_LINES | Per-line remote IRR from the delivery engine |
| dlv_stat_i | input | NUM_LINES | Per-line delivery status from the delivery engine |
| vec_o | output | 8*NUM_LINES | Per-line vector |
| dlv_mode_o | output | 3*NUM_LINES | Per-line delivery mode |
| dst_mode_o | output | NUM_LINES | Per-line destination mode |
| dst_o | output | 8*NUM_LINES | Per-line destination |
| trig_o | output | NUM_LINES | Per-line trigger mode |
| mask_o | output | NUM_LINES | Per-line mask |

## Verification
The checker watches several properties on every cycle. Identification reads never show bits outside 27:24, and version reads return the constant. The arbitration copy changes only after an identification write. High-word writes leave the low-word outputs steady, and low-word writes leave the destinations steady. Status bits on low-word reads follow the engine inputs, unimplemented indices read zero, and `rdata` holds when no read is strobed. The bench scenarios show the rest: the reset values, the exact field packing of written words, the readback of the last line's entry, that written values reach the per-line output ports, and that writes to the status positions have no effect.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int WORD_W      = 32;
   localparam int IDX_W       = 8;
   localparam int IDX_ID      = 8'h00;
   localparam int IDX_VER     = 8'h01;
   localparam int IDX_ARB     = 8'h02;
   localparam int REDIR_BASE  = 8'h10;
   localparam int ID_LSB      = 24;
   localparam int ID_W        = 4;
   localparam int DST_LSB     = 24;
   localparam int DST_W       = 8;
   // low-word bit positions
   localparam int B_DSTM      = 11;
   localparam int B_DSTAT     = 12;
   localparam int B_POL       = 13;
   localparam int B_RIRR      = 14;
   localparam int B_TRIG      = 15;
   localparam int B_MASK      = 16;

   typedef struct packed {
      logic       mask;
      logic       trig;
      logic       pol;
      logic       dstm;
      logic [2:0] dmode;
      logic [7:0] vec;
   } lo_fields_t;
endpackage

// File: rtl/intc_id_arb.sv
module intc_id_arb
   import intc_pkg::*;
#(
   parameter int FIELD_LSB = ID_LSB,
   parameter int FIELD_W   = ID_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               id_we,
   input  logic [WORD_W-1:0]  wdata,
   output logic [FIELD_W-1:0] id_o,
   output logic [FIELD_W-1:0] arb_o
);
   generate
      if (FIELD_LSB + FIELD_W > WORD_W) begin : g_bad_field
         $error("id field exceeds word");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_o  <= '0;
         arb_o <= '0;
      end else if (id_we) begin
         id_o  <= wdata[FIELD_LSB +: FIELD_W];
         arb_o <= wdata[FIELD_LSB +: FIELD_W];
      end
   end
endmodule

// File: rtl/intc_redir_slot.sv
module intc_redir_slot
   import intc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_lo,
   input  logic              we_hi,
   input  logic [WORD_W-1:0] wdata,
   input  logic              rirr_i,
   input  logic              dstat_i,
   output logic [WORD_W-1:0] lo_word,
   output logic [WORD_W-1:0] hi_word,
   output lo_fields_t        fields_o,
   output logic [DST_W-1:0]  dst_o
);
   lo_fields_t lo_q;
   logic [DST_W-1:0] dst_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q      <= '0;
         lo_q.mask <= 1'b1;
      end else if (we_lo) begin
         lo_q.vec   <= wdata[7:0];
         lo_q.dmode <= wdata[10:8];
         lo_q.dstm  <= wdata[B_DSTM];
         lo_q.pol   <= wdata[B_POL];
         lo_q.trig  <= wdata[B_TRIG];
         lo_q.mask  <= wdata[B_MASK];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     dst_q <= '0;
      else if (we_hi) dst_q <= wdata[DST_LSB +: DST_W];
   end

   always_comb begin
      lo_word          = '0;
      lo_word[7:0]     = lo_q.vec;
      lo_word[10:8]    = lo_q.dmode;
      lo_word[B_DSTM]  = lo_q.dstm;
      lo_word[B_DSTAT] = dstat_i;
      lo_word[B_POL]   = lo_q.pol;
      lo_word[B_RIRR]  = rirr_i;
      lo_word[B_TRIG]  = lo_q.trig;
      lo_word[B_MASK]  = lo_q.mask;
      hi_word          = '0;
      hi_word[DST_LSB +: DST_W] = dst_q;
   end

   assign fields_o = lo_q;
   assign dst_o    = dst_q;
endmodule

// File: rtl/intc_ind_regs.sv
module intc_ind_regs
   import intc_pkg::*;
#(
   parameter int         NUM_LINES = 24,
   parameter logic [7:0] VER_CODE  = 8'h11
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   idx_we,
   input  logic                   dat_we,
   input  logic                   rd_en,
   input  logic [WORD_W-1:0]      wdata,
   output logic [WORD_W-1:0]      rdata,
   input  logic [NUM_LINES-1:0]   remote_irr_i,
   input  logic [NUM_LINES-1:0]   dlv_stat_i,
   output logic [8*NUM_LINES-1:0] vec_o,
   output logic [3*NUM_LINES-1:0] dlv_mode_o,
   output logic [NUM_LINES-1:0]   dst_mode_o,
   output logic [8*NUM_LINES-1:0] dst_o,
   output logic [NUM_LINES-1:0]   trig_o,
   output logic [NUM_LINES-1:0]   mask_o
);
   localparam int REDIR_END = REDIR_BASE + 2 * NUM_LINES;
   localparam logic [WORD_W-1:0] VERSION_WORD =
      {8'h00, 8'(NUM_LINES - 1), 8'h00, VER_CODE};

   generate
      if (NUM_LINES < 1 || REDIR_END > (1 << IDX_W)) begin : g_bad_lines
         $error("NUM_LINES out of range for index width");
      end
   endgenerate

   logic [IDX_W-1:0]    idx_q;
   logic [ID_W-1:0]     id_val, arb_val;
   logic [WORD_W-1:0]   lo_w [NUM_LINES];
   logic [WORD_W-1:0]   hi_w [NUM_LINES];
   logic [WORD_W-1:0]   win;

   always_ff @(posedge clk) begin
      if (!rst_n)      idx_q <= '0;
      else if (idx_we) idx_q <= wdata[IDX_W-1:0];
   end

   intc_id_arb #(.FIELD_LSB(ID_LSB), .FIELD_W(ID_W)) u_id (
      .clk   (clk),
      .rst_n (rst_n),
      .id_we (dat_we && idx_q == IDX_W'(IDX_ID)),
      .wdata (wdata),
      .id_o  (id_val),
      .arb_o (arb_val)
   );

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      lo_fields_t f;
      intc_redir_slot u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .we_lo    (dat_we && idx_q == IDX_W'(REDIR_BASE + 2*g)),
         .we_hi    (dat_we && idx_q == IDX_W'(REDIR_BASE + 2*g + 1)),
         .wdata    (wdata),
         .rirr_i   (remote_irr_i[g]),
         .dstat_i  (dlv_stat_i[g]),
         .lo_word  (lo_w[g]),
         .hi_word  (hi_w[g]),
         .fields_o (f),
         .dst_o    (dst_o[8*g +: 8])
      );
      assign vec_o[8*g +: 8]      = f.vec;
      assign dlv_mode_o[3*g +: 3] = f.dmode;
      assign dst_mode_o[g]        = f.dstm;
      assign trig_o[g]            = f.trig;
      assign mask_o[g]            = f.mask;
   end

   always_comb begin
      win = '0;
      if (idx_q == IDX_W'(IDX_ID))
         win[ID_LSB +: ID_W] = id_val;
      else if (idx_q == IDX_W'(IDX_VER))
         win = VERSION_WORD;
      else if (idx_q == IDX_W'(IDX_ARB))
         win[ID_LSB +: ID_W] = arb_val;
      else begin
         for (int n = 0; n < NUM_LINES; n++) begin
            if (idx_q == IDX_W'(REDIR_BASE + 2*n))     win = lo_w[n];
            if (idx_q == IDX_W'(REDIR_BASE + 2*n + 1)) win = hi_w[n];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= win;
   end
endmodule

// File: rtl/intc_ind_regs_chk.sv
module intc_ind_regs_chk
   import intc_pkg::*;
#(
   parameter int         NUM_LINES = 24,
   parameter logic [7:0] VER_CODE  = 8'h11
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   dat_we,
   input logic                   rd_en,
   input logic [WORD_W-1:0]      rdata,
   input logic [IDX_W-1:0]       idx,
   input logic [ID_W-1:0]        arb,
   input logic [NUM_LINES-1:0]   remote_irr_i,
   input logic [NUM_LINES-1:0]   dlv_stat_i,
   input logic [8*NUM_LINES-1:0] vec_o,
   input logic [3*NUM_LINES-1:0] dlv_mode_o,
   input logic [8*NUM_LINES-1:0] dst_o,
   input logic [NUM_LINES-1:0]   trig_o,
   input logic [NUM_LINES-1:0]   mask_o
);
   localparam logic [WORD_W-1:0] VER_EXP =
      {8'h00, 8'(NUM_LINES - 1), 8'h00, VER_CODE};
   localparam int REDIR_END = REDIR_BASE + 2 * NUM_LINES;

   logic sel_lo, sel_hi, sel_none, exp_rirr, exp_dstat;
   always_comb begin
      sel_lo = 1'b0; sel_hi = 1'b0; exp_rirr = 1'b0; exp_dstat = 1'b0;
      for (int n = 0; n < NUM_LINES; n++) begin
         if (idx == IDX_W'(REDIR_BASE + 2*n)) begin
            sel_lo = 1'b1; exp_rirr = remote_irr_i[n]; exp_dstat = dlv_stat_i[n];
         end
         if (idx == IDX_W'(REDIR_BASE + 2*n + 1)) sel_hi = 1'b1;
      end
      sel_none = (int'(idx) > IDX_ARB) && !sel_lo && !sel_hi;
   end

   a_r1_id_bits_only: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && idx == IDX_W'(IDX_ID)) |=> ((rdata & ~32'h0F00_0000) == '0));
   a_r2_version_const: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && idx == IDX_W'(IDX_VER)) |=> (rdata == VER_EXP));
   a_r3_arb_only_on_id_write: assert property (@(posedge clk) disable iff (!rst_n)
      !(dat_we && idx == IDX_W'(IDX_ID)) |=> $stable(arb));
   a_r6_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && sel_hi) |=> ($stable(vec_o) && $stable(dlv_mode_o) &&
                              $stable(trig_o) && $stable(mask_o)));
   a_r7_lo_keeps_dst: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && sel_lo) |=> $stable(dst_o));
   a_r8_live_status: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel_lo) |=> (rdata[B_RIRR] == $past(exp_rirr) &&
                             rdata[B_DSTAT] == $past(exp_dstat)));
   a_r11_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel_none) |=> (rdata == '0));
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   initial a_cfg_span: assert (REDIR_END <= (1 << IDX_W));
endmodule

bind intc_ind_regs intc_ind_regs_chk #(.NUM_LINES(NUM_LINES), .VER_CODE(VER_CODE)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .dat_we       (dat_we),
   .rd_en        (rd_en),
   .rdata        (rdata),
   .idx          (idx_q),
   .arb          (arb_val),
   .remote_irr_i (remote_irr_i),
   .dlv_stat_i   (dlv_stat_i),
   .vec_o        (vec_o),
   .dlv_mode_o   (dlv_mode_o),
   .dst_o        (dst_o),
   .trig_o       (trig_o),
   .mask_o       (mask_o)
);

// File: tb/intc_ind_regs_bench.sv
module intc_ind_regs_bench;
   localparam int N = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic idx_we = 1'b0, dat_we = 1'b0, rd_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [N-1:0] remote_irr_i = '0, dlv_stat_i = '0;
   logic [8*N-1:0] vec_o, dst_o;
   logic [3*N-1:0] dlv_mode_o;
   logic [N-1:0] dst_mode_o, trig_o, mask_o;

   int tests = 0, fails = 0;

   always #2.5 clk = ~clk;

   intc_ind_regs #(.NUM_LINES(N), .VER_CODE(8'h11)) u_intc_ind_regs (
      .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .remote_irr_i(remote_irr_i),
      .dlv_stat_i(dlv_stat_i), .vec_o(vec_o), .dlv_mode_o(dlv_mode_o),
      .dst_mode_o(dst_mode_o), .dst_o(dst_o), .trig_o(trig_o), .mask_o(mask_o));

   typedef struct packed {
      logic [7:0]  ix;
      logic        wr;
      logic [31:0] wd;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t TBL [NV] = '{
      '{8'h00, 1'b0, 32'h0000_0000, 32'h0000_0000, 8'd1},  // R1 reset value
      '{8'h00, 1'b1, 32'hFFFF_FFFF, 32'h0F00_0000, 8'd1},  // R1 only 27:24
      '{8'h02, 1'b0, 32'h0000_0000, 32'h0F00_0000, 8'd3},  // R3 copy of id
      '{8'h02, 1'b1, 32'h0000_0000, 32'h0F00_0000, 8'd3},  // R3 write ignored
      '{8'h01, 1'b1, 32'hFFFF_FFFF, 32'h0017_0011, 8'd2},  // R2 read-only
      '{8'h00, 1'b1, 32'hF5A0_0000, 32'h0500_0000, 8'd1},  // R1 new id
      '{8'h02, 1'b0, 32'h0000_0000, 32'h0500_0000, 8'd3},  // R3 follows
      '{8'h10, 1'b0, 32'h0000_0000, 32'h0001_0000, 8'd9},  // R9 mask set
      '{8'h11, 1'b0, 32'h0000_0000, 32'h0000_0000, 8'd9},  // R9 dest zero
      '{8'h10, 1'b1, 32'hFFFF_FFFF, 32'h0001_AFFF, 8'd5},  // R5 packing, R8 status not stored
      '{8'h11, 1'b1, 32'hFFFF_FFFF, 32'hFF00_0000, 8'd6},  // R6 dest only
      '{8'h10, 1'b0, 32'h0000_0000, 32'h0001_AFFF, 8'd6},  // R6 low untouched
      '{8'h3E, 1'b1, 32'h0000_8123, 32'h0000_8123, 8'd5},  // R5 last line low
      '{8'h3F, 1'b1, 32'h5A00_1234, 32'h5A00_0000, 8'd6},  // R6 last line high
      '{8'h40, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 8'd11}, // R11 past end
      '{8'h0F, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 8'd11}, // R11 gap
      '{8'h10, 1'b1, 32'h0000_0000, 32'h0000_0000, 8'd7},  // R7 low write
      '{8'h11, 1'b0, 32'h0000_0000, 32'hFF00_0000, 8'd7}   // R7 dest kept
   };

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   // R4: index then optional data write then strobed read
   task automatic access(input logic [7:0] ix, input logic wr, input logic [31:0] wd,
                         output logic [31:0] rd);
      @(negedge clk); idx_we = 1'b1; wdata = {24'h0, ix};
      @(negedge clk); idx_we = 1'b0;
      if (wr) begin
         dat_we = 1'b1; wdata = wd;
         @(negedge clk); dat_we = 1'b0;
      end
      rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      rd = rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state at the ports
      check("R9 mask_o after reset", 32'(mask_o), 32'(24'hFF_FFFF));
      check("R9 vec_o after reset", 32'(vec_o[31:0]), 32'h0);
      check("R12 rdata after reset", rdata, 32'h0);

      for (int i = 0; i < NV; i++) begin
         access(TBL[i].ix, TBL[i].wr, TBL[i].wd, r);
         check($sformatf("R%0d table step %0d", TBL[i].req, i), r, TBL[i].exp);
      end

      // R10 exported fields
      check("R10 vec line 23", 32'(vec_o[8*23 +: 8]), 32'h23);
      check("R10 dlv_mode line 23", 32'(dlv_mode_o[3*23 +: 3]), 32'h1);
      check("R10 trig line 23", 32'(trig_o[23]), 32'h1);
      check("R10 mask line 23", 32'(mask_o[23]), 32'h0);
      check("R10 dst line 23", 32'(dst_o[8*23 +: 8]), 32'h5A);
      check("R10 dst line 0", 32'(dst_o[7:0]), 32'hFF);
      check("R10 mask line 0", 32'(mask_o[0]), 32'h0);
      check("R9 mask line 1 untouched", 32'(mask_o[1]), 32'h1);
      check("R11 no stray writes dst line 1", 32'(dst_o[15:8]), 32'h0);

      // R8 live status
      remote_irr_i[23] = 1'b1; dlv_stat_i[23] = 1'b1;
      access(8'h3E, 1'b0, 32'h0, r);
      check("R8 status shown", r, 32'h0000_D123);
      access(8'h3E, 1'b1, 32'h0000_8123, r);
      check("R8 write of zero status ignored", r, 32'h0000_D123);
      remote_irr_i[23] = 1'b0; dlv_stat_i[23] = 1'b0;
      access(8'h3E, 1'b0, 32'h0, r);
      check("R8 status cleared", r, 32'h0000_8123);

      // R12 hold without rd_en
      @(negedge clk); idx_we = 1'b1; wdata = 32'h01;
      @(negedge clk); idx_we = 1'b0;
      @(negedge clk);
      check("R12 rdata holds", rdata, 32'h0000_8123);
      rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      check("R2 version via R4 index", rdata, 32'h0017_0011);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule